// File: doc/BRIEF.md
# Per-Processor Counter and User Timer Bank

This block holds one timer for each of `N_PROC` processors plus a shared mode register. Each timer has two personalities. In counter mode it counts up on every tick, compares against a programmed limit, and raises its interrupt when the limit is reached. In user mode it turns into a 63-bit counter that software starts and stops and reads as two 32-bit halves; in that mode it never interrupts. Counts advance at bit 9 of the word view, so the low nine bits of every count read are zero. The tick that paces counting comes from outside the block, and so does whatever routes the interrupts.

Software reaches the registers through a request channel and a response channel, both valid/ready. A request names a window with `req_sel`: 0 is the system window, which holds the mode register, and k (1..N_PROC) is the window of processor k-1. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when no response is pending or when the pending response is being taken in that cycle. A write produces no response. An accepted read produces one response in the next cycle, and that response stays on `rsp_rdata` with `rsp_valid` high until `rsp_ready` takes it.

Word offsets (from `req_addr`): 0 is upper/limit, 1 is lower/count, 2 is limit-without-restart, 3 is run control, 4 is mode (system window only).

Top module: `proc_timer_bank`

## Requirements
- R1: After reset the mode register reads 0, every timer is in counter mode with run status 1, counts, limits and reached flags are 0, and all `irq` bits are low.
- R2: In counter mode a timer adds 512 to its count (bit 9 up) on each tick. When the next count would equal a nonzero limit, the count returns to 0, the reached flag (bit 31 of an offset 1 read) is set and `irq` goes high. Writing offset 0 stores bits 30..9 as the limit, zeroes the count and lowers `irq`. Writing offset 2 stores the limit and keeps the count.
- R3: In counter mode a read of offset 0 returns the limit in bits 30..9 and clears both the reached flag and `irq`.
- R4: In counter mode a write to offset 1 changes nothing.
- R5: The mode register sits at offset 4 of the system window, with bit i selecting user mode for processor i. Bits at or above N_PROC are dropped and read as 0. An offset 4 write through a processor window is ignored.
- R6: When a mode bit goes from 0 to 1, that timer lowers `irq`, stops, reads run status 0, keeps its count and reached flag, and has its limit forced to the maximum (0x7FFFFE00 when next read in counter mode).
- R7: When a mode bit goes from 1 to 0, that timer reads run status 1 and counts again in counter mode, with count bits above bit 30 of the word view cleared.
- R8: In user mode an offset 0 read returns count bits 62..32 in bits 30..0 and the reached flag in bit 31. An offset 1 read returns count bits 31..0, with bits 8..0 zero.
- R9: In user mode a write to offset 0 loads count bits 62..32 from data bits 30..0. A write to offset 1 loads count bits 31..9 from data bits 31..9. Either write clears the reached flag, and counting continues from the new 63-bit value.
- R10: Data bit 0 of an offset 3 write starts (1) or stops (0) the timer in user mode and is ignored in counter mode. A stopped timer holds its count through ticks. An offset 3 read returns the run status in bit 0 for a processor window and 0 for the system window.
- R11: A timer in user mode never drives its `irq` high.
- R12: `req_ready` equals `!rsp_valid || rsp_ready`. A read yields exactly one response one cycle after acceptance, held stable while `rsp_ready` is low. A write yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle count pulse, shared by all timers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | $clog2(N_PROC+1) | Window: 0 system, k processor k-1 |
| req_addr | input | 3 | Word offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data |
| irq | output | N_PROC | Per-processor limit interrupt |

## Verification
On every cycle the assertions check that a user-mode timer has no interrupt raised, that a counter-mode timer reports itself running, that the limit is at its maximum right after a switch into user mode, that a stopped user timer holds its count unless it is written, and that a stalled response does not change. The directed scenarios are needed for the values software sees: the wrap point and the reached flag, the read that clears the flag, the split-word loads and the carry from the lower word into the upper one, the ignored writes, the mode bits above N_PROC, and what a timer keeps or loses across each mode change.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
  localparam int WORD_W  = 32;
  localparam int FRAC_W  = 9;                  // low word bits that never count
  localparam int SHORT_W = WORD_W - 1 - FRAC_W;  // counter-mode count/limit width
  localparam int CNT_W   = 63 - FRAC_W;        // user-mode count width
  localparam int LOW_W   = WORD_W - FRAC_W;    // count bits in the lower word
  localparam int HIGH_W  = CNT_W - LOW_W;      // count bits in the upper word
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TOP      = 3'd0,
    REG_BOTTOM   = 3'd1,
    REG_LIM_KEEP = 3'd2,
    REG_RUN      = 3'd3,
    REG_MODE     = 3'd4
  } reg_off_e;
endpackage

// File: rtl/ptb_mode.sv
`timescale 1ns/1ps
module ptb_mode #(
  parameter int N_PROC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [N_PROC-1:0] wdata,
  output logic [N_PROC-1:0] mode,
  output logic [N_PROC-1:0] rise,
  output logic [N_PROC-1:0] fall
);
  logic [N_PROC-1:0] mode_q;

  assign rise = wr_en ? (wdata & ~mode_q) : '0;
  assign fall = wr_en ? (~wdata & mode_q) : '0;
  assign mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wdata;
  end
endmodule

// File: rtl/ptb_slice.sv
`timescale 1ns/1ps
module ptb_slice
  import ptb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              mode_rise,
  input  logic              mode_fall,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  localparam logic [SHORT_W-1:0] SHORT_MAX = '1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHORT_W-1:0] lim_q, lim_d;
  logic               reached_q, reached_d;
  logic               run_q, run_d;
  logic               irq_q, irq_d;
  logic [SHORT_W-1:0] short_nxt;
  logic               may_count;
  logic               lim_hit;

  assign short_nxt = cnt_q[SHORT_W-1:0] + 1'b1;
  assign may_count = tick && (user_mode ? run_q : 1'b1);
  assign lim_hit   = (lim_q != '0) ? (short_nxt == lim_q) : (short_nxt == SHORT_MAX);

  always_comb begin
    cnt_d     = cnt_q;
    lim_d     = lim_q;
    reached_d = reached_q;
    run_d     = run_q;
    irq_d     = irq_q;
    if (mode_rise) begin
      irq_d = 1'b0;
      run_d = 1'b0;
      lim_d = SHORT_MAX;
    end else if (mode_fall) begin
      run_d                     = 1'b1;
      cnt_d[CNT_W-1:SHORT_W] = '0;
    end else begin
      if (!user_mode && rd_en && addr == REG_TOP) begin
        reached_d = 1'b0;
        irq_d     = 1'b0;
      end
      if (may_count) begin
        if (user_mode) begin
          cnt_d = cnt_q + 1'b1;
          if (&cnt_q) reached_d = 1'b1;
        end else if (lim_hit) begin
          cnt_d = '0;
          if (lim_q != '0) begin
            reached_d = 1'b1;
            irq_d     = 1'b1;
          end
        end else begin
          cnt_d = {{(CNT_W-SHORT_W){1'b0}}, short_nxt};
        end
      end
      if (wr_en) begin
        if (user_mode) begin
          case (addr)
            REG_TOP: begin
              cnt_d[CNT_W-1:LOW_W] = wdata[HIGH_W-1:0];
              reached_d            = 1'b0;
            end
            REG_BOTTOM: begin
              cnt_d[LOW_W-1:0] = wdata[WORD_W-1:FRAC_W];
              reached_d        = 1'b0;
            end
            REG_RUN: run_d = wdata[0];
            default: ;
          endcase
        end else begin
          case (addr)
            REG_TOP: begin
              lim_d = wdata[WORD_W-2:FRAC_W];
              cnt_d = '0;
              irq_d = 1'b0;
            end
            REG_LIM_KEEP: lim_d = wdata[WORD_W-2:FRAC_W];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      run_q     <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      lim_q     <= lim_d;
      reached_q <= reached_d;
      run_q     <= run_d;
      irq_q     <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_TOP:
        rdata = user_mode ? {reached_q, cnt_q[CNT_W-1:LOW_W]}
                          : {1'b0, lim_q, {FRAC_W{1'b0}}};
      REG_BOTTOM:
        rdata = user_mode ? {cnt_q[LOW_W-1:0], {FRAC_W{1'b0}}}
                          : {reached_q, cnt_q[SHORT_W-1:0], {FRAC_W{1'b0}}};
      REG_RUN: rdata = {{(WORD_W-1){1'b0}}, run_q};
      default: rdata = '0;
    endcase
  end

  assign irq = irq_q;

  AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> !irq_q);  // R11
  AST_COUNTER_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> run_q);  // R7
  AST_LIMIT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rise |=> (lim_q == SHORT_MAX));  // R6
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !run_q && !wr_en && !mode_fall) |=> $stable(cnt_q));  // R10
endmodule

// File: rtl/ptb_port.sv
`timescale 1ns/1ps
module ptb_port
  import ptb_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [SEL_W-1:0]              req_sel,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [WORD_W-1:0]             rsp_rdata,
  input  logic [N_PROC-1:0][WORD_W-1:0] slice_rdata,
  input  logic [N_PROC-1:0]             mode_val,
  output logic [N_PROC-1:0]             slice_wr,
  output logic [N_PROC-1:0]             slice_rd,
  output logic                          mode_wr
);
  logic              accept;
  logic              sys_hit;
  logic [N_PROC-1:0] cpu_hit;
  logic [WORD_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign sys_hit   = (req_sel == '0);
  assign mode_wr   = accept && req_write && sys_hit && (req_addr == REG_MODE);

  for (genvar i = 0; i < N_PROC; i++) begin : g_dec
    assign cpu_hit[i]  = (req_sel == SEL_W'(i + 1));
    assign slice_wr[i] = accept && req_write && cpu_hit[i];
    assign slice_rd[i] = accept && !req_write && cpu_hit[i];
  end

  always_comb begin
    rd_mux = '0;
    if (sys_hit && req_addr == REG_MODE) rd_mux = WORD_W'(mode_val);
    for (int i = 0; i < N_PROC; i++) begin
      if (cpu_hit[i]) rd_mux = slice_rdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));  // R12
endmodule

// File: rtl/proc_timer_bank.sv
`timescale 1ns/1ps
module proc_timer_bank
  import ptb_pkg::*;
#(
  parameter int N_PROC = 4,
  localparam int SEL_W = $clog2(N_PROC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [N_PROC-1:0] irq
);
  logic [N_PROC-1:0][WORD_W-1:0] slice_rdata;
  logic [N_PROC-1:0]             mode, rise, fall;
  logic [N_PROC-1:0]             slice_wr, slice_rd;
  logic                          mode_wr;

  ptb_port #(.N_PROC(N_PROC), .SEL_W(SEL_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_sel     (req_sel),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .slice_rdata (slice_rdata),
    .mode_val    (mode),
    .slice_wr    (slice_wr),
    .slice_rd    (slice_rd),
    .mode_wr     (mode_wr)
  );

  ptb_mode #(.N_PROC(N_PROC)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (mode_wr),
    .wdata (req_wdata[N_PROC-1:0]),
    .mode  (mode),
    .rise  (rise),
    .fall  (fall)
  );

  for (genvar i = 0; i < N_PROC; i++) begin : g_tmr
    ptb_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .user_mode (mode[i]),
      .mode_rise (rise[i]),
      .mode_fall (fall[i]),
      .wr_en     (slice_wr[i]),
      .rd_en     (slice_rd[i]),
      .addr      (req_addr),
      .wdata     (req_wdata),
      .rdata     (slice_rdata[i]),
      .irq       (irq[i])
    );
  end
endmodule

// File: tb/tb_proc_timer_bank.sv
`timescale 1ns/1ps
module tb_proc_timer_bank;
  localparam int N = 4;
  localparam int SW = $clog2(N + 1);

  logic          clk = 0, rst_n = 0, tick = 0;
  logic          req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [SW-1:0] req_sel = '0;
  logic [2:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [N-1:0]  irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  proc_timer_bank #(.N_PROC(N)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_sel = SW'(sel); req_addr = 3'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int sel, input int addr, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = SW'(sel); req_addr = 3'(addr);
    @(negedge clk);
    req_valid = 0;
    data = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 4, v); check("R1 mode after reset", v, 0);
    rd(2, 3, v); check("R1 run status after reset", v, 1);
    rd(1, 1, v); check("R1 count after reset", v, 0);
    rd(1, 0, v); check("R1 limit after reset", v, 0);
    check("R1 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_counter;
    logic [31:0] v;
    wr(1, 0, 32'h0000_0A00);
    ticks(3);
    rd(1, 1, v); check("R2 count after 3 ticks", v, 32'h0000_0600);
    ticks(2);
    rd(1, 1, v); check("R2 reached on limit", v, 32'h8000_0000);
    check("R2 irq on limit", 32'(irq[0]), 1);
    rd(1, 0, v); check("R3 limit readback", v, 32'h0000_0A00);
    check("R3 irq cleared by limit read", 32'(irq[0]), 0);
    rd(1, 1, v); check("R3 reached cleared", v, 0);
  endtask

  task automatic t_ignored_count_write;
    logic [31:0] v;
    ticks(2);
    wr(1, 1, 32'h1234_5600);
    rd(1, 1, v); check("R4 count write ignored", v, 32'h0000_0400);
    wr(1, 2, 32'h0000_1000);
    rd(1, 1, v); check("R2 limit keep leaves count", v, 32'h0000_0400);
    rd(1, 0, v); check("R2 limit keep value", v, 32'h0000_1000);
    ticks(6);
    check("R2 irq at new limit", 32'(irq[0]), 1);
  endtask

  task automatic t_to_user;
    logic [31:0] v;
    wr(0, 4, 32'hFFFF_FFF1);
    rd(0, 4, v); check("R5 high mode bits dropped", v, 1);
    check("R6 irq lowered on entry", 32'(irq[0]), 0);
    rd(1, 3, v); check("R6 stopped on entry", v, 0);
    ticks(3);
    rd(1, 1, v); check("R6 stopped count holds", v, 0);
    rd(1, 0, v); check("R8 upper word carries reached", v, 32'h8000_0000);
  endtask

  task automatic t_user;
    logic [31:0] v;
    wr(1, 0, 32'h0000_0005);
    wr(1, 1, 32'hFFFF_FFFF);
    rd(1, 0, v); check("R9 upper load clears reached", v, 32'h0000_0005);
    rd(1, 1, v); check("R8 lower word low bits zero", v, 32'hFFFF_FE00);
    wr(1, 3, 32'h1);
    rd(1, 3, v); check("R10 start", v, 1);
    ticks(1);
    rd(1, 0, v); check("R9 carry into upper", v, 32'h0000_0006);
    rd(1, 1, v); check("R9 lower wraps", v, 0);
    wr(1, 3, 32'h0);
    ticks(2);
    rd(1, 1, v); check("R10 stop holds count", v, 0);
    check("R11 no irq in user mode", 32'(irq[0]), 0);
    wr(2, 3, 32'h0);
    rd(2, 3, v); check("R10 run write ignored in counter mode", v, 1);
    rd(0, 3, v); check("R10 system status reads zero", v, 0);
  endtask

  task automatic t_to_counter;
    logic [31:0] v;
    wr(0, 4, 32'h0);
    rd(1, 3, v); check("R7 running after return", v, 1);
    rd(1, 0, v); check("R6 limit forced max", v, 32'h7FFF_FE00);
    rd(1, 1, v); check("R7 upper count cleared", v, 0);
    ticks(2);
    rd(1, 1, v); check("R7 counting resumes", v, 32'h0000_0400);
    wr(1, 4, 32'hF);
    rd(0, 4, v); check("R5 mode write via cpu window ignored", v, 0);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_sel = SW'(2); req_addr = 3'd3;
    @(negedge clk);
    req_sel = '0; req_addr = 3'd4;
    check("R12 ready low while stalled", 32'(req_ready), 0);
    check("R12 first response data", rsp_rdata, 1);
    @(negedge clk);
    check("R12 response held", {31'b0, rsp_valid} | (rsp_rdata << 1), 32'h3);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R12 second response", rsp_rdata, 0);
    check("R12 second valid", 32'(rsp_valid), 1);
    @(negedge clk);
    check("R12 response drained", 32'(rsp_valid), 0);
    wr(0, 0, 32'h0);
    check("R12 write has no response", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_counter();
    t_ignored_count_write();
    t_to_user();
    t_user();
    t_to_counter();
    t_handshake();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule